// File: doc/BRIEF.md
# Dual store queue write buffer

This block collects processor stores aimed at a reserved address window into two independent 32-byte queues and writes a queue out to external memory as one burst when the processor asks for it. Each store into the window lands in the selected queue in a single cycle. Address bit 5 picks the queue and bits [4:2] pick the 32-bit word inside it. A queue reaches memory only when a flush command, shaped like a prefetch, is issued to an address inside the window. The flush address chooses the queue and, together with a per-queue base value, sets the burst target.

The processor port also carries privilege information. A user-mode access is checked in one of two ways. With address translation off, a single mode input grants or refuses it. With translation on, a per-page protection input decides instead. Supervisor accesses are always allowed. A refused access produces a one-cycle error pulse and has no other effect.

The memory side is a simple burst write master. It sends eight 32-bit beats with a valid/ready handshake and flags the final beat.

Top module: `sq_write_buffer`

## Requirements
- R1: After reset `cpu_stall`, `cpu_err` and `bm_valid` are low, and every word of both queues reads as zero when flushed.
- R2: An allowed store with `cpu_addr[31:26]` equal to 6'b111000 writes `cpu_wdata` into queue `cpu_addr[5]`, word `cpu_addr[4:2]`, at the next clock edge, without stalling when that queue is not being flushed.
- R3: An allowed flush raises `bm_valid` one cycle after it is accepted. It then sends words 0 through 7 of the named queue in ascending order, advancing one word per cycle in which `bm_ready` is high, and holds `bm_data` steady while `bm_ready` is low. `bm_last` is high only on the eighth beat, and `bm_valid` falls after that beat is taken.
- R4: During a burst `bm_addr` equals {base of the flushed queue (`q0_base` or `q1_base`, 6 bits), flush `cpu_addr[25:5]`, 5'b00000}.
- R5: An allowed store to the queue being flushed holds `cpu_stall` high and writes nothing until the cycle after the last beat is accepted. A store to the other queue during that burst completes without stall.
- R6: An allowed flush issued while a burst is in progress holds `cpu_stall` high until that burst ends.
- R7: With `xlat_en` low, a user access (`cpu_user` high) is allowed only if `user_mode_ok` is high. Accesses with `cpu_user` low are always allowed.
- R8: With `xlat_en` high, a user access is allowed only if `page_user_ok` is high, whatever `user_mode_ok` is.
- R9: A refused access in the window raises `cpu_err` for exactly the following cycle. It does not stall, leaves both queues unchanged, and starts no burst.
- R10: A request whose `cpu_addr[31:26]` is not 6'b111000 causes no stall, no error, no queue write and no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_flush | input | 1 | 1: flush command, 0: store |
| cpu_addr | input | 32 | Request address |
| cpu_wdata | input | 32 | Store data |
| cpu_user | input | 1 | Request made in user mode |
| xlat_en | input | 1 | Address translation enabled |
| user_mode_ok | input | 1 | User access grant while translation is off |
| page_user_ok | input | 1 | Per-page user access grant while translation is on |
| q0_base | input | 6 | Upper burst address bits for queue 0 |
| q1_base | input | 6 | Upper burst address bits for queue 1 |
| cpu_stall | output | 1 | Request held, retry next cycle |
| cpu_err | output | 1 | One-cycle pulse after a refused access |
| bm_valid | output | 1 | Burst beat valid |
| bm_ready | input | 1 | Memory accepts the beat |
| bm_addr | output | 32 | 32-byte aligned burst address |
| bm_data | output | 32 | Beat data |
| bm_last | output | 1 | Final beat of the burst |

## Verification
A corrupted queue word can stay hidden until its queue is flushed. It then shows as a wrong `bm_data` beat, so every scenario ends by flushing the queues it touched, and denied or out-of-window stores are always followed by a flush. A wrong beat counter or busy flag shows up at once: `bm_last` on the wrong beat, `bm_valid` held too long, or `cpu_stall` raised for the idle queue, each of which differs from the reference model in the same cycle. A wrong permission decision appears one cycle later on `cpu_err`, and in the same cycle as a missing stall or an unexpected burst start.

// File: rtl/sqwb_pkg.sv
// Shared sizes for the dual store queue write buffer.
// Assumes a 32-bit address, 32-bit words and two queues selected by one address bit.
package sqwb_pkg;
    parameter int SQ_AW    = 32;
    parameter int SQ_DW    = 32;
    parameter int SQ_WORDS = 8;
    parameter int SQ_NQ    = 2;

    localparam int WIDX_W  = $clog2(SQ_WORDS);
    localparam int OFS_W   = WIDX_W + 2;
    localparam int QSEL_B  = OFS_W;
    localparam int BASE_W  = 6;
    localparam int QIDX_W  = (SQ_NQ > 1) ? $clog2(SQ_NQ) : 1;
    localparam logic [BASE_W-1:0] WIN_TAG = 6'b111000;

    typedef logic [SQ_DW-1:0] word_t;
    typedef logic [SQ_AW-1:0] addr_t;
    typedef logic [WIDX_W-1:0] widx_t;
    typedef logic [QIDX_W-1:0] qidx_t;
    typedef logic [BASE_W-1:0] base_t;
endpackage

// File: rtl/sqwb_access.sv
// Request decoder: window hit, privilege check, stall and write/flush enables.
// Assumes one burst engine, so any flush waits while a burst is active.
module sqwb_access
    import sqwb_pkg::*;
(
    input  logic  cpu_valid,
    input  logic  cpu_flush,
    input  addr_t cpu_addr,
    input  logic  cpu_user,
    input  logic  xlat_en,
    input  logic  user_mode_ok,
    input  logic  page_user_ok,
    input  logic  busy,
    input  qidx_t busy_q,
    output logic  stall,
    output logic  st_we,
    output logic  fl_go,
    output logic  denied,
    output qidx_t sel_q,
    output widx_t widx
);
    logic hit;
    logic allowed;
    logic q_busy;

    // Decode the window, the queue and the word, and grant or refuse the access.
    always_comb begin
        hit     = cpu_valid && (cpu_addr[SQ_AW-1 -: BASE_W] == WIN_TAG);
        allowed = !cpu_user || (xlat_en ? page_user_ok : user_mode_ok);
        sel_q   = qidx_t'(cpu_addr[QSEL_B]);
        widx    = cpu_addr[OFS_W-1:2];
        q_busy  = busy && (busy_q == sel_q);
        denied  = hit && !allowed;
        stall   = hit && allowed && (cpu_flush ? busy : q_busy);
        st_we   = hit && allowed && !cpu_flush && !stall;
        fl_go   = hit && allowed && cpu_flush && !stall;
    end
endmodule

// File: rtl/sqwb_store.sv
// Queue storage: SQ_NQ queues of SQ_WORDS words, one write port and one read port.
// Assumes the write enable is already gated by the stall logic.
module sqwb_store
    import sqwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  qidx_t wq,
    input  widx_t widx,
    input  word_t wdata,
    input  qidx_t rq,
    input  widx_t ridx,
    output word_t rdata
);
    word_t rd_words [SQ_NQ];

    for (genvar gq = 0; gq < SQ_NQ; gq++) begin : g_q
        word_t words [SQ_WORDS];

        // Clear the queue on reset, otherwise write the addressed word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < SQ_WORDS; i++) words[i] <= '0;
            end else if (we && (wq == qidx_t'(gq))) begin
                words[widx] <= wdata;
            end
        end

        assign rd_words[gq] = words[ridx];
    end

    assign rdata = rd_words[rq];
endmodule

// File: rtl/sqwb_burst.sv
// Burst engine: on a flush, sends the queue's words in ascending order over valid/ready.
// Assumes the requested queue is not written while its burst runs.
module sqwb_burst
    import sqwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fl_go,
    input  qidx_t fl_q,
    input  addr_t fl_addr,
    input  base_t base0,
    input  base_t base1,
    input  logic  bm_ready,
    input  word_t rd_data,
    output logic  active,
    output qidx_t act_q,
    output widx_t beat,
    output logic  bm_valid,
    output addr_t bm_addr,
    output word_t bm_data,
    output logic  bm_last
);
    base_t sel_base;

    // Pick the base value of the queue named by the flush.
    always_comb sel_base = (fl_q == qidx_t'(0)) ? base0 : base1;

    // Track the running burst and step the beat on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            act_q   <= '0;
            beat    <= '0;
            bm_addr <= '0;
        end else if (active) begin
            if (bm_ready) begin
                beat <= beat + 1'b1;
                if (beat == widx_t'(SQ_WORDS - 1)) active <= 1'b0;
            end
        end else if (fl_go) begin
            active  <= 1'b1;
            act_q   <= fl_q;
            beat    <= '0;
            bm_addr <= {sel_base, fl_addr[SQ_AW-BASE_W-1:OFS_W], {OFS_W{1'b0}}};
        end
    end

    assign bm_valid = active;
    assign bm_data  = rd_data;
    assign bm_last  = active && (beat == widx_t'(SQ_WORDS - 1));
endmodule

// File: rtl/sq_write_buffer.sv
// Top of the dual store queue write buffer: decoder, queue storage, burst engine, error pulse.
// Assumes the processor holds a stalled request unchanged until cpu_stall falls.
module sq_write_buffer
    import sqwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_flush,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    input  logic              cpu_user,
    input  logic              xlat_en,
    input  logic              user_mode_ok,
    input  logic              page_user_ok,
    input  logic [5:0]        q0_base,
    input  logic [5:0]        q1_base,
    output logic              cpu_stall,
    output logic              cpu_err,
    output logic              bm_valid,
    input  logic              bm_ready,
    output logic [31:0]       bm_addr,
    output logic [31:0]       bm_data,
    output logic              bm_last
);
    logic  st_we, fl_go, denied, active;
    qidx_t sel_q, act_q;
    widx_t widx, beat;
    word_t rd_data;

    sqwb_access u_access (
        .cpu_valid    (cpu_valid),
        .cpu_flush    (cpu_flush),
        .cpu_addr     (cpu_addr),
        .cpu_user     (cpu_user),
        .xlat_en      (xlat_en),
        .user_mode_ok (user_mode_ok),
        .page_user_ok (page_user_ok),
        .busy         (active),
        .busy_q       (act_q),
        .stall        (cpu_stall),
        .st_we        (st_we),
        .fl_go        (fl_go),
        .denied       (denied),
        .sel_q        (sel_q),
        .widx         (widx)
    );

    sqwb_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .wq    (sel_q),
        .widx  (widx),
        .wdata (cpu_wdata),
        .rq    (act_q),
        .ridx  (beat),
        .rdata (rd_data)
    );

    sqwb_burst u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .fl_go    (fl_go),
        .fl_q     (sel_q),
        .fl_addr  (cpu_addr),
        .base0    (q0_base),
        .base1    (q1_base),
        .bm_ready (bm_ready),
        .rd_data  (rd_data),
        .active   (active),
        .act_q    (act_q),
        .beat     (beat),
        .bm_valid (bm_valid),
        .bm_addr  (bm_addr),
        .bm_data  (bm_data),
        .bm_last  (bm_last)
    );

    // Register a refused access into a single-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_err <= 1'b0;
        else        cpu_err <= denied;
    end
endmodule

// File: rtl/sqwb_checker.sv
// Port-level properties of the write buffer, bound onto every sq_write_buffer instance.
// Assumes the top-level port names; keeps its own beat count.
module sqwb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_valid,
    input logic        cpu_flush,
    input logic [31:0] cpu_addr,
    input logic        cpu_user,
    input logic        xlat_en,
    input logic        user_mode_ok,
    input logic        page_user_ok,
    input logic        cpu_stall,
    input logic        cpu_err,
    input logic        bm_valid,
    input logic        bm_ready,
    input logic [31:0] bm_addr,
    input logic [31:0] bm_data,
    input logic        bm_last
);
    logic       in_win, ok, refused, flush_taken;
    logic [3:0] beats;

    // Independent view of the window hit and the privilege decision.
    always_comb begin
        in_win      = cpu_valid && (cpu_addr[31:26] == 6'b111000);
        ok          = !cpu_user || (xlat_en ? page_user_ok : user_mode_ok);
        refused     = in_win && !ok;
        flush_taken = in_win && ok && cpu_flush && !cpu_stall;
    end

    // Count accepted beats of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                     beats <= '0;
        else if (bm_valid && bm_ready)  beats <= bm_last ? 4'd0 : beats + 4'd1;
    end

    p_last_on_eighth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bm_valid |-> (bm_last == (beats == 4'd7)));
    p_hold_when_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_valid && !bm_ready) |=> (bm_valid && $stable(bm_data) && $stable(bm_addr) && $stable(bm_last)));
    p_start_after_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bm_valid && flush_taken) |=> bm_valid);
    p_stall_needs_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> bm_valid);
    p_err_follows_refusal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> cpu_err);
    p_err_only_after_refusal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !refused |=> !cpu_err);
    p_refused_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refused |-> !cpu_stall);
    p_outside_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !in_win) |-> !cpu_stall);
endmodule

bind sq_write_buffer sqwb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .cpu_flush    (cpu_flush),
    .cpu_addr     (cpu_addr),
    .cpu_user     (cpu_user),
    .xlat_en      (xlat_en),
    .user_mode_ok (user_mode_ok),
    .page_user_ok (page_user_ok),
    .cpu_stall    (cpu_stall),
    .cpu_err      (cpu_err),
    .bm_valid     (bm_valid),
    .bm_ready     (bm_ready),
    .bm_addr      (bm_addr),
    .bm_data      (bm_data),
    .bm_last      (bm_last)
);

// File: tb/sim_sq_write_buffer.sv
// Bench: behavioural reference model compared with the ports on every clock.
module sim_sq_write_buffer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid, cpu_flush, cpu_user, xlat_en, user_mode_ok, page_user_ok, bm_ready;
    logic [31:0] cpu_addr, cpu_wdata;
    logic [5:0]  q0_base, q1_base;
    logic        cpu_stall, cpu_err, bm_valid, bm_last;
    logic [31:0] bm_addr, bm_data;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit rdy_slow = 1'b0;

    // Reference model state
    logic [31:0] mq [2][8];
    bit          m_active;
    int          m_q, m_beat;
    logic [31:0] m_addr;
    bit          m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_write_buffer u0 (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_flush(cpu_flush),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_user(cpu_user), .xlat_en(xlat_en),
        .user_mode_ok(user_mode_ok), .page_user_ok(page_user_ok), .q0_base(q0_base),
        .q1_base(q1_base), .cpu_stall(cpu_stall), .cpu_err(cpu_err), .bm_valid(bm_valid),
        .bm_ready(bm_ready), .bm_addr(bm_addr), .bm_data(bm_data), .bm_last(bm_last)
    );

    function automatic logic [31:0] sq_addr(int q, int w);
        return {6'b111000, 20'hABCDE, q[0], w[2:0], 2'b00};
    endfunction

    function automatic bit m_hit();
        return cpu_valid && (cpu_addr[31:26] == 6'b111000);
    endfunction

    function automatic bit m_ok();
        if (!cpu_user) return 1'b1;
        return xlat_en ? page_user_ok : user_mode_ok;
    endfunction

    function automatic bit m_stall();
        if (!(m_hit() && m_ok())) return 1'b0;
        if (cpu_flush) return m_active;
        return m_active && (m_q == int'(cpu_addr[5]));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // One clock: compare outputs against the model, then advance the model with the same inputs.
    task automatic step(string tag);
        bit st;
        bm_ready = rdy_slow ? ((cyc % 3) != 1) : 1'b1;
        #1;
        st = rst_n ? m_stall() : 1'b0;
        chk({tag, " R5/R6 stall"}, {31'b0, cpu_stall}, {31'b0, st});
        chk({tag, " R9 err"}, {31'b0, cpu_err}, {31'b0, m_err});
        chk({tag, " R3 valid"}, {31'b0, bm_valid}, {31'b0, m_active});
        if (m_active) begin
            chk({tag, " R3 data"}, bm_data, mq[m_q][m_beat]);
            chk({tag, " R3 last"}, {31'b0, bm_last}, {31'b0, m_beat == 7});
            chk({tag, " R4 addr"}, bm_addr, m_addr);
        end
        @(posedge clk);
        if (!rst_n) begin
            foreach (mq[i, j]) mq[i][j] = '0;
            m_active = 0; m_q = 0; m_beat = 0; m_addr = '0; m_err = 0;
        end else begin
            m_err = m_hit() && !m_ok();
            if (m_active && bm_ready) begin
                if (m_beat == 7) m_active = 0;
                else m_beat++;
            end else if (!m_active && m_hit() && m_ok() && cpu_flush) begin
                m_active = 1; m_beat = 0; m_q = int'(cpu_addr[5]);
                m_addr = {(m_q == 0) ? q0_base : q1_base, cpu_addr[25:5], 5'b0};
            end
            if (m_hit() && m_ok() && !cpu_flush && !st)
                mq[int'(cpu_addr[5])][int'(cpu_addr[4:2])] = cpu_wdata;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        cpu_valid = 0;
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Issue a request and hold it until the model says it is taken.
    task automatic req(bit fl, logic [31:0] a, logic [31:0] d, bit usr, string tag);
        bit st;
        cpu_valid = 1; cpu_flush = fl; cpu_addr = a; cpu_wdata = d; cpu_user = usr;
        do begin
            st = m_stall();
            step(tag);
        end while (st);
        cpu_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 0; cpu_valid = 0; cpu_flush = 0; cpu_addr = '0; cpu_wdata = '0;
        cpu_user = 0; xlat_en = 0; user_mode_ok = 0; page_user_ok = 0; bm_ready = 1;
        q0_base = 6'h15; q1_base = 6'h2A;
        @(negedge clk);
        idle(3, "R1 reset");
        rst_n = 1;
        // R1: flush of an untouched queue returns zeros
        req(1, sq_addr(1, 0), '0, 0, "R1 flush q1");
        idle(10, "R1 drain");
        // R2: fill both queues with supervisor stores
        for (int w = 0; w < 8; w++) req(0, sq_addr(0, w), 32'h1000_0000 + w, 0, "R2 q0");
        for (int w = 7; w >= 0; w--) req(0, sq_addr(1, w), 32'h2000_0000 + w * 3, 0, "R2 q1");
        // R3, R4: flush q0 with a stalling memory; R5: store to busy q0 stalls, q1 proceeds
        rdy_slow = 1;
        req(1, sq_addr(0, 5), '0, 0, "R3 flush q0");
        req(0, sq_addr(1, 2), 32'hBEEF_0002, 0, "R5 other queue");
        req(0, sq_addr(0, 3), 32'hCAFE_0003, 0, "R5 busy queue");
        // R6: flush while busy stalls
        req(1, sq_addr(0, 0), '0, 0, "R6 flush q0 again");
        req(1, sq_addr(1, 0), '0, 0, "R6 flush q1");
        idle(14, "R3 drain");
        rdy_slow = 0;
        // R7: user access with translation off
        user_mode_ok = 0;
        req(0, sq_addr(0, 1), 32'hDEAD_0001, 1, "R7 denied store");
        req(1, sq_addr(0, 0), '0, 1, "R7 denied flush");
        idle(2, "R9 pulse end");
        user_mode_ok = 1;
        req(0, sq_addr(0, 6), 32'h7777_0006, 1, "R7 allowed store");
        // R8: translation on, page bit decides
        xlat_en = 1; page_user_ok = 0;
        req(0, sq_addr(1, 4), 32'hDEAD_0004, 1, "R8 denied store");
        req(0, sq_addr(1, 5), 32'hDEAD_0005, 1, "R8 denied back-to-back");
        page_user_ok = 1; user_mode_ok = 0;
        req(0, sq_addr(1, 7), 32'h8888_0007, 1, "R8 allowed store");
        xlat_en = 0;
        // R10: outside the window
        req(0, 32'hE400_0000, 32'hBAD0_0000, 0, "R10 store above");
        req(1, 32'hDFFF_FFE0, '0, 0, "R10 flush below");
        idle(2, "R10 idle");
        // R9, R10: contents unchanged, seen through flushes
        req(1, sq_addr(0, 0), '0, 0, "R9 flush q0");
        idle(10, "R9 drain q0");
        q1_base = 6'h3F;
        req(1, sq_addr(1, 0), '0, 0, "R9 flush q1");
        idle(10, "R9 drain q1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule